// File: doc/BRIEF.md
# Power Monitor Conversion Sequencer

This block runs the measurement schedule of a current and power monitor. It alternates between a shunt-voltage conversion and a bus-voltage conversion, each lasting a programmable number of clock ticks. It takes the ADC result present on its sample inputs at the end of each conversion. From every shunt sample it derives a current value using a calibration word. From every bus sample it derives a power value from that current.

All four quantities are summed over a programmable number of samples. The averaged set is published to registered outputs in one step, together with a single-cycle ready pulse and an overflow indication. A 16-bit configuration word selects the operating mode, both conversion times and the averaging depth. The modes are continuous, single-shot triggered and power-down. Writing the configuration word always restarts the schedule.

Top module: `pmon_seq`

## Requirements
- R1: Configuration word layout: bits [2:0] select the mode, [5:3] the shunt time code, [8:6] the bus time code, and [11:9] the averaging code; bits [15:12] are ignored. After reset all result outputs, `res_ovf` and `conv_rdy` are 0. The configuration becomes 16'h0127: continuous shunt-and-bus mode, both time codes 4, one sample. Conversion begins on the first clock after reset.
- R2: Per shunt sample, current = floor(shunt × cal / 2048), with shunt signed and cal unsigned. The result saturates to the signed 16-bit range, and a zero calibration gives zero.
- R3: Per bus sample, power = floor(|current| × bus / 20000), with bus unsigned. The current used is the most recent per-sample current, and the result saturates at 65535.
- R4: Averaging codes 0..7 select 1, 4, 16, 64, 128, 256, 512 or 1024 samples. Each published value is the sum over the run shifted right by log2 of that count, arithmetically for shunt and current.
- R5: A conversion with time code c lasts CT_OFFSET + (CT_STEP << c) clock ticks. With avg samples per run, `conv_rdy` rises avg × (shunt time + bus time) + 1 cycles after the configuration write edge in the combined modes.
- R6: Modes 001 and 101 convert shunt only and update only the shunt and current outputs. Modes 010 and 110 convert bus only and update only the bus and power outputs.
- R7: In the triggered modes 001, 010 and 011, one configuration write produces exactly one published result set. Writing the same value again produces another.
- R8: In the continuous modes 101, 110 and 111, runs repeat back to back, and each new result set follows the previous one after one full run plus one cycle.
- R9: A configuration write discards the run in progress, including its partial sums, and starts a new run with the new settings. No ready pulse appears in the cycle after a write.
- R10: Modes 000 and 100 are power-down: no sample is taken, no ready pulse appears, and all outputs hold.
- R11: The first conversion after leaving power-down begins only after WAKE_TICKS recovery cycles.
- R12: `res_ovf` is published with each result set. It is 1 when any current or power computation in that run saturated, and it changes only with a ready pulse.
- R13: `conv_rdy` is a one-cycle pulse. The result outputs change only in the cycle where it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| cal_word | input | DW | Calibration value, unsigned |
| adc_shunt | input | DW | Shunt ADC sample, signed |
| adc_bus | input | DW | Bus ADC sample, unsigned |
| shunt_avg | output | DW | Averaged shunt value, signed |
| bus_avg | output | DW | Averaged bus value |
| cur_avg | output | DW | Averaged current, signed |
| pwr_avg | output | DW | Averaged power |
| res_ovf | output | 1 | Saturation seen in the published run |
| conv_rdy | output | 1 | Result set published (one cycle) |

## Verification
The arithmetic is swept over a grid of shunt, calibration and bus samples with one-sample runs. The grid covers zero, ±1, the signed extremes and a full-scale calibration, which separates floor rounding, saturation on both signs, the magnitude taken for power and the overflow flag. Every averaging code and every time-code pair is run, and the cycle distance to the ready pulse is measured, so a wrong sample count, conversion length or shift shows up as a timing or value mismatch. Mode tests change the inputs between runs to show which outputs a shunt-only or bus-only run leaves untouched. Aborted runs, power-down windows and repeated triggers are checked by counting ready pulses and by watching the outputs hold.

// File: rtl/pmon_pkg.sv
`timescale 1ns/1ps
package pmon_pkg;

  localparam int MAX_AVG_LOG2 = 10;

  typedef enum logic [2:0] {
    ST_OFF, ST_WAKE, ST_SHUNT, ST_BUS, ST_PUB, ST_IDLE
  } seq_st_t;

  typedef struct packed {
    logic [3:0] rsvd;
    logic [2:0] avg;
    logic [2:0] bct;
    logic [2:0] sct;
    logic [2:0] mode;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{rsvd: 4'h0, avg: 3'd0, bct: 3'd4,
                                 sct: 3'd4, mode: 3'b111};

  function automatic logic [3:0] avg_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd0;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd7;
      3'd5:    return 4'd8;
      3'd6:    return 4'd9;
      default: return 4'd10;
    endcase
  endfunction

  function automatic logic mode_active(input logic [2:0] m);
    return m[1:0] != 2'b00;
  endfunction

  function automatic seq_st_t first_state(input logic [2:0] m);
    return m[0] ? ST_SHUNT : ST_BUS;
  endfunction

endpackage

// File: rtl/pmon_ctrl.sv
`timescale 1ns/1ps
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int TICK_W     = 16,
  parameter int CT_OFFSET  = 2,
  parameter int CT_STEP    = 2,
  parameter int WAKE_TICKS = 10,
  parameter int NS_W       = MAX_AVG_LOG2 + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [2:0]  run_mode,
  output logic [3:0]  avg_sh,
  output logic        take_shunt,
  output logic        take_bus,
  output logic        publish
);

  cfg_t              cfg_q;
  cfg_t              cfg_n;
  seq_st_t           st;
  logic [TICK_W-1:0] cnt;
  logic [TICK_W-1:0] sh_lim;
  logic [TICK_W-1:0] bu_lim;
  logic [NS_W-1:0]   nsmp;
  logic [NS_W-1:0]   nlast;
  logic              last;
  logic              unused_rsvd;

  assign cfg_n       = cfg_t'(cfg_wdata);
  assign unused_rsvd = ^{cfg_n.rsvd, cfg_q.rsvd};
  assign run_mode    = cfg_q.mode;
  assign avg_sh      = avg_shift(cfg_q.avg);

  assign sh_lim = TICK_W'(CT_OFFSET) + (TICK_W'(CT_STEP) << cfg_q.sct) - TICK_W'(1);
  assign bu_lim = TICK_W'(CT_OFFSET) + (TICK_W'(CT_STEP) << cfg_q.bct) - TICK_W'(1);
  assign nlast  = (NS_W'(1) << avg_sh) - NS_W'(1);
  assign last   = (nsmp == nlast);

  assign take_shunt = !cfg_we && (st == ST_SHUNT) && (cnt == sh_lim);
  assign take_bus   = !cfg_we && (st == ST_BUS) && (cnt == bu_lim);
  assign publish    = !cfg_we && (st == ST_PUB);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      st    <= ST_SHUNT;
      cnt   <= '0;
      nsmp  <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_n;
      cnt   <= '0;
      nsmp  <= '0;
      if (!mode_active(cfg_n.mode))
        st <= ST_OFF;
      else if (st == ST_OFF || st == ST_WAKE)
        st <= ST_WAKE;
      else
        st <= first_state(cfg_n.mode);
    end else begin
      case (st)
        ST_WAKE: begin
          if (cnt == TICK_W'(WAKE_TICKS - 1)) begin
            cnt <= '0;
            st  <= first_state(cfg_q.mode);
          end else begin
            cnt <= cnt + TICK_W'(1);
          end
        end
        ST_SHUNT: begin
          if (take_shunt) begin
            cnt <= '0;
            if (cfg_q.mode[1])
              st <= ST_BUS;
            else if (last)
              st <= ST_PUB;
            else
              nsmp <= nsmp + NS_W'(1);
          end else begin
            cnt <= cnt + TICK_W'(1);
          end
        end
        ST_BUS: begin
          if (take_bus) begin
            cnt <= '0;
            if (last) begin
              st <= ST_PUB;
            end else begin
              nsmp <= nsmp + NS_W'(1);
              st   <= first_state(cfg_q.mode);
            end
          end else begin
            cnt <= cnt + TICK_W'(1);
          end
        end
        ST_PUB: begin
          nsmp <= '0;
          st   <= cfg_q.mode[2] ? first_state(cfg_q.mode) : ST_IDLE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pmon_arith.sv
`timescale 1ns/1ps
module pmon_arith #(
  parameter int DW        = 16,
  parameter int CUR_SHIFT = 11,
  parameter int PWR_DIV   = 20000
) (
  input  logic [DW-1:0] shunt,
  input  logic [DW-1:0] cal,
  input  logic [DW-1:0] bus,
  input  logic [DW-1:0] cur_in,
  output logic [DW-1:0] cur_val,
  output logic          cur_ovf,
  output logic [DW-1:0] pwr_val,
  output logic          pwr_ovf
);

  localparam int PW = 2 * DW + 1;
  localparam logic signed [PW-1:0] CMAX = PW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] CMIN = ~CMAX;
  localparam logic [PW-1:0]        PMAX = PW'({DW{1'b1}});

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] quo;
  logic [DW:0]          mag;
  logic [PW-1:0]        pprod;
  logic [PW-1:0]        pquo;

  // Current: signed product scaled down by a power of two (floor).
  always_comb begin
    prod    = $signed(shunt) * $signed({1'b0, cal});
    quo     = prod >>> CUR_SHIFT;
    cur_ovf = (quo > CMAX) || (quo < CMIN);
    if (quo > CMAX)
      cur_val = CMAX[DW-1:0];
    else if (quo < CMIN)
      cur_val = CMIN[DW-1:0];
    else
      cur_val = quo[DW-1:0];
  end

  // Power: current magnitude times bus, divided by the fixed constant.
  always_comb begin
    mag     = cur_in[DW-1] ? ({1'b0, ~cur_in} + (DW+1)'(1)) : {1'b0, cur_in};
    pprod   = PW'(mag) * PW'(bus);
    pquo    = pprod / PW'(PWR_DIV);
    pwr_ovf = pquo > PMAX;
    pwr_val = pwr_ovf ? {DW{1'b1}} : pquo[DW-1:0];
  end

endmodule

// File: rtl/pmon_accum.sv
`timescale 1ns/1ps
module pmon_accum #(
  parameter int DW     = 16,
  parameter int ACC_W  = 27,
  parameter bit SIGNED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add,
  input  logic [DW-1:0] val,
  input  logic [3:0]    sh,
  output logic [DW-1:0] avg
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] ext;
  logic [ACC_W-1:0] shv;

  generate
    if (SIGNED) begin : g_signed
      assign ext = {{(ACC_W-DW){val[DW-1]}}, val};
      assign shv = $signed(acc) >>> sh;
    end else begin : g_unsigned
      assign ext = {{(ACC_W-DW){1'b0}}, val};
      assign shv = acc >> sh;
    end
  endgenerate

  assign avg = shv[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (add)
      acc <= acc + ext;
  end

endmodule

// File: rtl/pmon_seq.sv
`timescale 1ns/1ps
module pmon_seq
  import pmon_pkg::*;
#(
  parameter int DW         = 16,
  parameter int TICK_W     = 16,
  parameter int CT_OFFSET  = 2,
  parameter int CT_STEP    = 2,
  parameter int WAKE_TICKS = 10,
  parameter int CUR_SHIFT  = 11,
  parameter int PWR_DIV    = 20000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic [DW-1:0] cal_word,
  input  logic [DW-1:0] adc_shunt,
  input  logic [DW-1:0] adc_bus,
  output logic [DW-1:0] shunt_avg,
  output logic [DW-1:0] bus_avg,
  output logic [DW-1:0] cur_avg,
  output logic [DW-1:0] pwr_avg,
  output logic          res_ovf,
  output logic          conv_rdy
);

  localparam int NS_W  = MAX_AVG_LOG2 + 1;
  localparam int ACC_W = DW + MAX_AVG_LOG2 + 1;
  localparam int NQ    = 4;

  logic [2:0]           run_mode;
  logic [3:0]           avg_sh;
  logic                 take_shunt;
  logic                 take_bus;
  logic                 publish;
  logic                 acc_clr;
  logic [DW-1:0]        cur_val;
  logic [DW-1:0]        pwr_val;
  logic                 cur_ovf;
  logic                 pwr_ovf;
  logic [DW-1:0]        cur_last;
  logic                 run_ovf;
  logic [NQ-1:0][DW-1:0] q_val;
  logic [NQ-1:0][DW-1:0] q_avg;
  logic [NQ-1:0]        q_add;

  pmon_ctrl #(
    .TICK_W(TICK_W), .CT_OFFSET(CT_OFFSET), .CT_STEP(CT_STEP),
    .WAKE_TICKS(WAKE_TICKS), .NS_W(NS_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .run_mode(run_mode), .avg_sh(avg_sh), .take_shunt(take_shunt),
    .take_bus(take_bus), .publish(publish)
  );

  pmon_arith #(.DW(DW), .CUR_SHIFT(CUR_SHIFT), .PWR_DIV(PWR_DIV)) u_arith (
    .shunt(adc_shunt), .cal(cal_word), .bus(adc_bus), .cur_in(cur_last),
    .cur_val(cur_val), .cur_ovf(cur_ovf), .pwr_val(pwr_val), .pwr_ovf(pwr_ovf)
  );

  assign acc_clr = publish || cfg_we;

  // Quantity order: 0 shunt, 1 bus, 2 current, 3 power (even = signed).
  assign q_val = {pwr_val, cur_val, adc_bus, adc_shunt};
  assign q_add = {take_bus, take_shunt, take_bus, take_shunt};

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_acc
      pmon_accum #(.DW(DW), .ACC_W(ACC_W), .SIGNED((g % 2) == 0)) u_acc (
        .clk(clk), .rst(rst), .clr(acc_clr), .add(q_add[g]),
        .val(q_val[g]), .sh(avg_sh), .avg(q_avg[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      cur_last <= '0;
    else if (take_shunt)
      cur_last <= cur_val;
  end

  always_ff @(posedge clk) begin
    if (rst || acc_clr)
      run_ovf <= 1'b0;
    else if ((take_shunt && cur_ovf) || (take_bus && pwr_ovf))
      run_ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shunt_avg <= '0;
      bus_avg   <= '0;
      cur_avg   <= '0;
      pwr_avg   <= '0;
      res_ovf   <= 1'b0;
      conv_rdy  <= 1'b0;
    end else begin
      conv_rdy <= publish;
      if (publish) begin
        res_ovf <= run_ovf;
        if (run_mode[0]) begin
          shunt_avg <= q_avg[0];
          cur_avg   <= q_avg[2];
        end
        if (run_mode[1]) begin
          bus_avg <= q_avg[1];
          pwr_avg <= q_avg[3];
        end
      end
    end
  end

endmodule

// File: rtl/pmon_seq_chk.sv
`timescale 1ns/1ps
module pmon_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [2:0]    cfg_mode,
  input logic          rdy,
  input logic          ovf,
  input logic [DW-1:0] cur,
  input logic [DW-1:0] pwr
);

  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);                                            // R13
  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> $stable(cur));                                   // R13
  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> $stable(pwr));                                   // R13
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode[1:0] == 2'b00) |-> !rdy);                       // R10
  AST_WR_ABORT: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> !rdy);                                         // R9
  AST_OVF_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf) |-> rdy);                                   // R12

endmodule

bind pmon_seq pmon_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(run_mode),
  .rdy(conv_rdy), .ovf(res_ovf), .cur(cur_avg), .pwr(pwr_avg)
);

// File: tb/pmon_seq_bench.sv
`timescale 1ns/1ps
module pmon_seq_bench;

  localparam int DW  = 16;
  localparam int CTO = 2;
  localparam int CTS = 2;
  localparam int WK  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic [DW-1:0] cal_word = '0;
  logic [DW-1:0] adc_shunt = '0;
  logic [DW-1:0] adc_bus = '0;
  logic [DW-1:0] shunt_avg, bus_avg, cur_avg, pwr_avg;
  logic          res_ovf, conv_rdy;

  int     tests = 0;
  int     fails = 0;
  longint cyc = 0;
  longint t0 = 0;
  int     rdy_cnt = 0;

  pmon_seq #(.DW(DW), .CT_OFFSET(CTO), .CT_STEP(CTS), .WAKE_TICKS(WK)) u_pmon_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cal_word(cal_word), .adc_shunt(adc_shunt), .adc_bus(adc_bus),
    .shunt_avg(shunt_avg), .bus_avg(bus_avg), .cur_avg(cur_avg),
    .pwr_avg(pwr_avg), .res_ovf(res_ovf), .conv_rdy(conv_rdy)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (conv_rdy) rdy_cnt <= rdy_cnt + 1;

  function automatic longint ticks(input int c);
    return CTO + (CTS << c);
  endfunction

  function automatic int nsamp(input int a);
    int t[8] = '{1, 4, 16, 64, 128, 256, 512, 1024};
    return t[a];
  endfunction

  function automatic logic [15:0] mk(input int m, input int sc, input int bc, input int a);
    return {4'b0, 3'(a), 3'(bc), 3'(sc), 3'(m)};
  endfunction

  function automatic longint cur_raw(input longint sh, input longint ca);
    longint p;
    p = sh * ca;
    return p >>> 11;
  endfunction

  function automatic longint sat_cur(input longint r);
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return r;
  endfunction

  function automatic longint pwr_raw(input longint c, input longint bu);
    longint m;
    m = (c < 0) ? -c : c;
    return (m * bu) / 20000;
  endfunction

  function automatic longint sat_pwr(input longint r);
    return (r > 65535) ? 65535 : r;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    #1 t0 = cyc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rdy(output longint dt);
    dt = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (conv_rdy) begin
        dt = cyc - t0;
        return;
      end
    end
  endtask

  function automatic longint s16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  // Combined triggered run (mode 011) with constant inputs.
  task automatic run_comb(input string tg, input int a, input int sc, input int bc,
                          input longint sh, input longint ca, input longint bu);
    longint dt, cr, c, pr, p;
    adc_shunt = 16'(sh);
    cal_word  = 16'(ca);
    adc_bus   = 16'(bu);
    wr(mk(3'b011, sc, bc, a));
    wait_rdy(dt);
    cr = cur_raw(sh, ca);
    c  = sat_cur(cr);
    pr = pwr_raw(c, bu);
    p  = sat_pwr(pr);
    chk({tg, " R5 time"}, dt, nsamp(a) * (ticks(sc) + ticks(bc)) + 1);
    chk({tg, " R4 shunt"}, s16(shunt_avg), sh);
    chk({tg, " R4 bus"}, longint'(bus_avg), bu);
    chk({tg, " R2 cur"}, s16(cur_avg), c);
    chk({tg, " R3 pwr"}, longint'(pwr_avg), p);
    chk({tg, " R12 ovf"}, longint'(res_ovf),
        longint'((cr != c) || (pr != p)));
  endtask

  initial begin
    longint dt;
    int     rc;
    logic [DW-1:0] h_sh, h_bu, h_cu, h_pw;
    int sh_l[8] = '{0, 1, -1, 8000, -8000, 32767, -32768, 12345};
    int ca_l[6] = '{0, 1, 2048, 2560, 40000, 65535};
    int bu_l[4] = '{0, 9584, 20000, 65535};

    // R1 reset state and default configuration
    adc_shunt = 16'd8000;
    cal_word  = 16'd2560;
    adc_bus   = 16'd9584;
    repeat (5) @(negedge clk);
    chk("R1 reset cur", longint'(cur_avg), 0);
    chk("R1 reset pwr", longint'(pwr_avg), 0);
    chk("R1 reset shunt/bus", longint'(shunt_avg | bus_avg), 0);
    chk("R1 reset rdy/ovf", longint'({conv_rdy, res_ovf}), 0);
    rst = 1'b0;
    t0  = cyc;
    wait_rdy(dt);
    chk("R1 R5 default timing", dt, 2 * ticks(4) + 1);
    chk("R2 default cur", s16(cur_avg), 10000);
    chk("R3 default pwr", longint'(pwr_avg), 4792);
    chk("R8 default continuous", longint'(bus_avg), 9584);

    // R2 R3 R12 arithmetic sweep with single-sample runs
    foreach (sh_l[i])
      foreach (ca_l[j])
        foreach (bu_l[k])
          run_comb("sweep", 0, 0, 0, sh_l[i], ca_l[j], bu_l[k]);

    // R4 every averaging depth
    for (int a = 0; a < 8; a++)
      run_comb("R4 avg", a, 0, 0, -1234, 3000, 50000);

    // R5 every conversion time code
    for (int c = 0; c < 8; c++)
      run_comb("R5 ct", 0, c, 7 - c, 4321, 2048, 1000);

    // R6 shunt-only then bus-only
    run_comb("R6 base", 0, 0, 0, 1000, 4096, 30000);
    adc_shunt = 16'(-500);
    adc_bus   = 16'd111;
    wr(mk(3'b001, 1, 0, 0));
    wait_rdy(dt);
    chk("R6 shunt-only time", dt, ticks(1) + 1);
    chk("R6 shunt-only shunt", s16(shunt_avg), -500);
    chk("R6 shunt-only cur", s16(cur_avg), -1000);
    chk("R6 shunt-only bus held", longint'(bus_avg), 30000);
    chk("R6 shunt-only pwr held", longint'(pwr_avg), 3000);
    adc_shunt = 16'd7777;
    adc_bus   = 16'd40000;
    wr(mk(3'b010, 0, 2, 0));
    wait_rdy(dt);
    chk("R6 bus-only time", dt, ticks(2) + 1);
    chk("R6 bus-only bus", longint'(bus_avg), 40000);
    chk("R6 bus-only pwr", longint'(pwr_avg), 2000);
    chk("R6 bus-only shunt held", s16(shunt_avg), -500);
    chk("R6 bus-only cur held", s16(cur_avg), -1000);

    // R7 one shot per write, R13 pulse width
    run_comb("R7 shot", 0, 0, 0, 2000, 2048, 20000);
    @(negedge clk);
    chk("R13 rdy one cycle", longint'(conv_rdy), 0);
    rc = rdy_cnt;
    repeat (200) @(negedge clk);
    chk("R7 no second result", longint'(rdy_cnt - rc), 0);
    run_comb("R7 rewrite", 0, 0, 0, 3000, 2048, 20000);

    // R8 continuous repetition with changing inputs
    adc_shunt = 16'd100;
    cal_word  = 16'd2048;
    adc_bus   = 16'd500;
    wr(mk(3'b111, 0, 0, 0));
    wait_rdy(dt);
    chk("R8 first", dt, 9);
    for (int n = 1; n <= 3; n++) begin
      t0 = cyc;
      adc_shunt = 16'(100 * (n + 1));
      wait_rdy(dt);
      chk("R8 period", dt, 9);
      chk("R8 fresh shunt", s16(shunt_avg), 100 * (n + 1));
    end

    // R9 abort long continuous run
    adc_shunt = 16'd9000;
    wr(mk(3'b111, 0, 0, 3));
    rc = rdy_cnt;
    repeat (100) @(negedge clk);
    adc_shunt = 16'(-77);
    adc_bus   = 16'd1234;
    wr(mk(3'b011, 0, 0, 0));
    wait_rdy(dt);
    chk("R9 abort time", dt, 9);
    chk("R9 no stale result", longint'(rdy_cnt - rc), 0);
    chk("R9 partial discarded", s16(shunt_avg), -77);
    chk("R9 bus", longint'(bus_avg), 1234);

    // R10 power-down holds, R11 recovery
    h_sh = shunt_avg; h_bu = bus_avg; h_cu = cur_avg; h_pw = pwr_avg;
    wr(mk(3'b000, 0, 0, 0));
    rc = rdy_cnt;
    adc_shunt = 16'd555;
    adc_bus   = 16'd666;
    repeat (150) @(negedge clk);
    wr(mk(3'b100, 0, 0, 0));
    repeat (150) @(negedge clk);
    chk("R10 no ready", longint'(rdy_cnt - rc), 0);
    chk("R10 shunt held", longint'(shunt_avg), longint'(h_sh));
    chk("R10 bus held", longint'(bus_avg), longint'(h_bu));
    chk("R10 cur/pwr held", longint'({cur_avg, pwr_avg}), longint'({h_cu, h_pw}));
    wr(mk(3'b011, 0, 0, 0));
    wait_rdy(dt);
    chk("R11 recovery time", dt, WK + 9);
    chk("R11 new shunt", s16(shunt_avg), 555);

    // R12 overflow cleared by next clean run
    run_comb("R12 sat", 0, 0, 0, 32767, 65535, 65535);
    run_comb("R12 clean", 0, 0, 0, 10, 2048, 10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule